// File: doc/BRIEF.md
# Serial Presence-Detect Memory Slave

This block is a two-wire serial slave that models the presence-detect memory of a memory module. It holds 256 bytes and answers at a 7-bit device address whose upper four bits are fixed and whose lower three bits come from strap inputs. The board ties those straps high or low. A host can set the internal byte pointer, write bytes, and read bytes either from the current pointer or, after a repeated START, from a pointer it has just set.

Parameters fill the array at reset. The lower half, bytes 0 to 127, is locked: bytes written there are acknowledged but not stored. The upper half stays writable. The byte pointer advances after every data byte moved in either direction and wraps from 255 to 0.

Both bus lines are sampled by the system clock through synchronizers. START and STOP are recognised when SDA moves while SCL is high. The block only ever pulls SDA low; it never drives it high.

Top module: `spd_eeprom_slave`

## Requirements
- R1: After reset the array reads: byte 0 = 0x80, byte 1 = 0x08, byte k for 2 <= k <= 62 = (37*k + 5) mod 256 (default fill parameters), byte 63 = sum of bytes 0..62 mod 256, and bytes 64..255 = 0x00.
- R2: The device address is 4'b1010 followed by strap[2], strap[1], strap[0], with the R/W bit as the eighth bit (1 = read). The block pulls SDA low in the ninth clock only on a match. On a mismatch it gives no ACK and ignores the bus until the next START.
- R3: In a write transaction, the first byte after the device address loads the byte pointer and is acknowledged.
- R4: Each further write byte is stored at the pointer when the pointer is 128 or above, is acknowledged, and the pointer then increments.
- R5: Write bytes aimed at pointers 0..127 are acknowledged, leave the array unchanged, and still advance the pointer.
- R6: A read returns the byte at the pointer, MSB first, and then increments the pointer.
- R7: The pointer wraps from 255 to 0 on both reads and writes.
- R8: A master ACK after a read byte makes the block send the next byte. A master NACK ends the read: the block releases SDA and stays released until a STOP or START.
- R9: A repeated START after the pointer has been set restarts device address decoding, which gives a random read.
- R10: A STOP in any state returns the block to idle with SDA released. SDA is pulled only in ACK slots and read data bits.
- R11: The pointer survives a STOP, so a later current-address read continues from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples both bus lines |
| rst_n | input | 1 | Active-low reset; reloads array and pointer |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap | input | 3 | Board straps giving the low three device address bits |
| sda_pull | output | 1 | High to pull the data line low |

## Verification
The store of a write byte and the pointer wrap from 255 to 0 happen in the same cycle. Whether the next byte lands in the locked half depends on both. The bench writes at 254, 255 and then 0. It checks that the ACKs arrive, that a current-address read then returns byte 1, and that a random read from 254 returns the two new bytes followed by the untouched byte 0. A second pairing is a master NACK followed directly by a STOP. It is judged by the line staying released across extra clocks before the STOP.

// File: rtl/spd_slave_pkg.sv
package spd_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_MEMADR,
        ST_WRDATA,
        ST_ACK,
        ST_RDDATA,
        ST_MACK
    } xfer_st_e;

    typedef enum logic [1:0] {
        AFT_MEMADR,
        AFT_WRDATA,
        AFT_RDDATA
    } after_ack_e;

    // Reset content of one array byte, computed from the fill parameters
    function automatic logic [7:0] boot_byte(input int idx, input int mul, input int add);
        int acc;
        if (idx == 0) return 8'h80;
        if (idx == 1) return 8'h08;
        if (idx >= 2 && idx <= 62) return 8'((idx * mul + add) & 255);
        if (idx == 63) begin
            acc = 8'h80 + 8'h08;
            for (int k = 2; k <= 62; k++) acc = acc + ((k * mul + add) & 255);
            return 8'(acc & 255);
        end
        return 8'h00;
    endfunction

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_lvl_o
);
    localparam int LEN = STAGES + 1;

    typedef struct packed {
        logic [LEN-1:0] scl;
        logic [LEN-1:0] sda;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d     = q;
        d.scl = {q.scl[LEN-2:0], scl_i};
        d.sda = {q.sda[LEN-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl: '1, sda: '1};
        else        q <= d;
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = q.scl[STAGES-1];
    assign scl_old = q.scl[STAGES];
    assign sda_now = q.sda[STAGES-1];
    assign sda_old = q.sda[STAGES];

    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
    assign sda_lvl_o  = sda_now;
endmodule

// File: rtl/spd_store.sv
module spd_store
    import spd_slave_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int LOCK_BYTES = 128,
    parameter int FILL_MUL   = 37,
    parameter int FILL_ADD   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_BYTES);

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) mem_d[wr_addr_i] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= boot_byte(i, FILL_MUL, FILL_ADD);
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // R5
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_addr_i >= LOCK_A));
endmodule

// File: rtl/spd_xfer_fsm.sv
module spd_xfer_fsm
    import spd_slave_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          LOCK_BYTES = 128,
    parameter logic [3:0]  DEV_PREFIX = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic [7:0]        rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              sda_pull_o
);
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_BYTES);
    localparam logic [ADDR_W-1:0] PTR_MAX = '1;

    typedef struct packed {
        xfer_st_e          st;
        after_ack_e        nxt;
        logic [3:0]        cnt;
        logic [7:0]        shr;
        logic [ADDR_W-1:0] ptr;
        logic              pull;
        logic              mnack;
    } fsm_t;

    fsm_t d, q;
    logic wr_en_c, step_c, load_c, addr_hit;

    assign addr_hit = (q.shr[7:1] == {DEV_PREFIX, strap_i});

    always_comb begin
        d       = q;
        wr_en_c = 1'b0;
        step_c  = 1'b0;
        load_c  = 1'b0;
        if (stop_i) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
            d.cnt  = '0;
        end else if (start_i) begin
            d.st   = ST_DEVADR;
            d.pull = 1'b0;
            d.cnt  = '0;
        end else begin
            case (q.st)
                ST_DEVADR, ST_MEMADR, ST_WRDATA: begin
                    if (scl_rise_i) begin
                        d.shr = {q.shr[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == 4'd8) begin
                        d.cnt  = '0;
                        d.st   = ST_ACK;
                        d.pull = 1'b1;
                        if (q.st == ST_DEVADR) begin
                            if (addr_hit) begin
                                d.nxt = q.shr[0] ? AFT_RDDATA : AFT_MEMADR;
                            end else begin
                                d.st   = ST_IDLE;
                                d.pull = 1'b0;
                            end
                        end else if (q.st == ST_MEMADR) begin
                            d.ptr = q.shr[ADDR_W-1:0];
                            d.nxt = AFT_WRDATA;
                        end else begin
                            wr_en_c = (q.ptr >= LOCK_A);
                            step_c  = 1'b1;
                            d.nxt   = AFT_WRDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        case (q.nxt)
                            AFT_MEMADR: begin d.st = ST_MEMADR; d.pull = 1'b0; end
                            AFT_WRDATA: begin d.st = ST_WRDATA; d.pull = 1'b0; end
                            default:    load_c = 1'b1;
                        endcase
                    end
                end
                ST_RDDATA: begin
                    if (scl_fall_i) begin
                        if (q.cnt == 4'd7) begin
                            d.st   = ST_MACK;
                            d.pull = 1'b0;
                            d.cnt  = '0;
                        end else begin
                            d.shr  = {q.shr[6:0], 1'b0};
                            d.pull = ~q.shr[6];
                            d.cnt  = q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        d.mnack = sda_i;
                    end else if (scl_fall_i) begin
                        if (q.mnack) d.st = ST_IDLE;
                        else         load_c = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (load_c) begin
            d.shr  = rd_data_i;
            d.pull = ~rd_data_i[7];
            d.cnt  = '0;
            d.st   = ST_RDDATA;
            step_c = 1'b1;
        end
        if (step_c) d.ptr = q.ptr + ADDR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, nxt: AFT_MEMADR, cnt: '0, shr: '0,
                   ptr: '0, pull: 1'b0, mnack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o  = q.ptr;
    assign wr_en_o    = wr_en_c;
    assign wr_addr_o  = q.ptr;
    assign wr_data_o  = q.shr;
    assign sda_pull_o = q.pull;

    // R10
    pull_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pull |-> (q.st == ST_ACK || q.st == ST_RDDATA));
    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !q.pull);
    // R9
    restart_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.st == ST_DEVADR && q.cnt == 4'd0));
    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_c && q.ptr == PTR_MAX) |=> (q.ptr == '0));
    // R2
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DEVADR && !stop_i && !start_i && scl_fall_i &&
         q.cnt == 4'd8 && !addr_hit) |=> (!q.pull && q.st == ST_IDLE));
endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave
    import spd_slave_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         LOCK_BYTES  = 128,
    parameter logic [3:0] DEV_PREFIX  = 4'b1010,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILL_MUL    = 37,
    parameter int         FILL_ADD    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap,
    output logic       sda_pull
);
    logic scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic wr_en;

    spd_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_in),
        .sda_i      (sda_in),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt),
        .sda_lvl_o  (sda_lvl)
    );

    spd_xfer_fsm #(
        .ADDR_W     (ADDR_W),
        .LOCK_BYTES (LOCK_BYTES),
        .DEV_PREFIX (DEV_PREFIX)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_evt),
        .stop_i     (stop_evt),
        .sda_i      (sda_lvl),
        .strap_i    (strap),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .sda_pull_o (sda_pull)
    );

    spd_store #(
        .ADDR_W     (ADDR_W),
        .LOCK_BYTES (LOCK_BYTES),
        .FILL_MUL   (FILL_MUL),
        .FILL_ADD   (FILL_ADD)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data)
    );
endmodule

// File: tb/spd_eeprom_slave_tb.sv
module spd_eeprom_slave_tb_top;
    localparam int QTR = 10;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic dut_pull;
    logic sda_line;

    assign sda_line = !(m_low || dut_pull);
    always #4 clk = ~clk;

    spd_eeprom_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .strap    (STRAP),
        .sda_pull (dut_pull)
    );

    int total = 0;
    int bad = 0;
    int ref_mem [256];
    int ref_ptr = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_low = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_low = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq();
            m_scl = 1'b1; wq();
            check(!dut_pull, "R10 no pull in master bit", int'(dut_pull), 0);
            wq();
            m_scl = 1'b0; wq();
        end
        m_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        ack = !sda_line;
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i] = sda_line;
            wq();
            m_scl = 1'b0; wq();
        end
        m_low = give_ack; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_low = 1'b0;
    endtask

    task automatic set_ptr(input int a, input string req);
        bit ack;
        bus_start();
        wr_byte(DEV_W, ack);
        check(ack, "R2 device ack", int'(ack), 1);
        wr_byte(8'(a), ack);
        check(ack, req, int'(ack), 1);
        ref_ptr = a;
    endtask

    task automatic wr_data(input logic [7:0] v, input string req);
        bit ack;
        wr_byte(v, ack);
        check(ack, req, int'(ack), 1);
        if (ref_ptr >= 128) ref_mem[ref_ptr] = v;
        ref_ptr = (ref_ptr + 1) % 256;
    endtask

    task automatic rd_seq(input int n, input bool_restart, input string req);
        bit ack;
        logic [7:0] v;
        if (bool_restart) bus_start();
        wr_byte(DEV_R, ack);
        check(ack, "R2 read device ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i != n - 1, v);
            check(int'(v) == ref_mem[ref_ptr], req, int'(v), ref_mem[ref_ptr]);
            ref_ptr = (ref_ptr + 1) % 256;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] v;
        int sum;
        for (int k = 0; k < 256; k++) ref_mem[k] = 0;
        ref_mem[0] = 8'h80;
        ref_mem[1] = 8'h08;
        for (int k = 2; k <= 62; k++) ref_mem[k] = (37 * k + 5) % 256;
        sum = 0;
        for (int k = 0; k <= 62; k++) sum += ref_mem[k];
        ref_mem[63] = sum % 256;

        repeat (5) @(negedge clk);
        check(!dut_pull, "R10 reset released", int'(dut_pull), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 R6 R9: random read of bytes 0..63 and checksum
        set_ptr(0, "R3 pointer byte ack");
        rd_seq(64, 1, "R1 R6 reset content");
        bus_stop();
        sum = 0;
        for (int k = 0; k <= 62; k++) sum += ref_mem[k];
        check(ref_mem[63] == sum % 256, "R1 checksum byte 63", ref_mem[63], sum % 256);

        // R2: wrong address gets no ACK and later bytes are ignored
        bus_start();
        wr_byte({4'b1010, 3'b010, 1'b0}, ack);
        check(!ack, "R2 mismatch no ack", int'(ack), 0);
        wr_byte(8'h00, ack);
        check(!ack, "R2 ignored after mismatch", int'(ack), 0);
        bus_stop();

        // R5: locked writes acked but not stored
        set_ptr(10, "R3 pointer byte ack");
        wr_data(8'h5A, "R5 locked write ack");
        wr_data(8'h5B, "R5 locked write ack");
        bus_stop();
        set_ptr(10, "R3 pointer byte ack");
        rd_seq(2, 1, "R5 locked bytes unchanged");
        bus_stop();

        // R4 R11: writable half, then current-address read after stop
        set_ptr(200, "R3 pointer byte ack");
        wr_data(8'h11, "R4 write ack");
        wr_data(8'h22, "R4 write ack");
        wr_data(8'h33, "R4 write ack");
        bus_stop();
        rd_seq(1, 1, "R11 current address after stop");
        bus_stop();
        set_ptr(200, "R3 pointer byte ack");
        rd_seq(4, 1, "R4 written bytes");
        bus_stop();

        // R7: write across the wrap, store and wrap in one cycle
        set_ptr(254, "R3 pointer byte ack");
        wr_data(8'hC1, "R7 write ack");
        wr_data(8'hC2, "R7 write ack");
        wr_data(8'hC3, "R7 R5 write at 0 ack");
        bus_stop();
        rd_seq(1, 1, "R7 pointer wrapped to 1");
        bus_stop();
        set_ptr(254, "R3 pointer byte ack");
        rd_seq(3, 1, "R7 read wrap");

        // R8: after master NACK the line stays released
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1'b1; wq();
            v[i] = sda_line;
            wq(); m_scl = 1'b0; wq();
        end
        check(v == 8'hFF, "R8 released after nack", int'(v), 8'hFF);
        bus_stop();

        // R10: STOP in the middle of a pointer byte leaves the pointer
        bus_start();
        wr_byte(DEV_W, ack);
        check(ack, "R2 device ack", int'(ack), 1);
        for (int i = 0; i < 4; i++) begin
            m_low = 1'b1; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
        end
        bus_stop();
        check(!dut_pull, "R10 idle after stop", int'(dut_pull), 0);
        rd_seq(2, 1, "R10 pointer kept over aborted write");
        bus_stop();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule